// File: doc/BRIEF.md
# Debug Port Halt and Flash Erase Controller

This block is a boundary-scan test access port with two private instructions added to it. One instruction connects a one-bit halt register to the scan chain. Updating that register stops or releases a processor core through the `cpu_halt` level. The other instruction starts an erase of on-chip non-volatile memory as soon as it is loaded into the instruction register. While it is loaded, the scan chain runs through a one-bit stage that always reads as zero.

The instruction register is five bits wide. Its capture value reports the live erase-busy flag and the protection status from the memory controller. A programmer therefore polls for the end of an erase by rescanning the instruction register. The erase request leaves the block as a one-cycle `erase_start` pulse. Completion comes back on `erase_done_i`. A build option models a device with no non-volatile memory; there the erase instruction does nothing and never reports busy.

All state changes on the rising edge of the test clock. `trst_n` is an asynchronous, active-low reset.

Top module: `jtag_halt_erase`

## Requirements
- R1: While `trst_n` is low, and on any edge taken in the reset state, the controller sets `cpu_halt` to 0 and loads the all-ones instruction. Five consecutive TMS-high clocks reach the reset state from any state.
- R2: Capture-IR loads the five-bit value {protect, 0, busy, 0, 1} (bit 4 down to bit 0). Bit 0 is the first bit out on `tdo`.
- R3: When Update-IR loads opcode 0x0F while busy is clear, busy is set and `erase_start` is high for exactly one cycle, both on that edge. No data-register scan is involved.
- R4: Loading 0x0F again while busy is set produces no `erase_start` pulse.
- R5: Busy clears on the edge at which `erase_done_i` is sampled high.
- R6: With 0x0F selected, the data stage captures 0 and ignores `tdi`, so `tdo` reads 0 on every Shift-DR cycle.
- R7: With the halt opcode (default 0x11) selected, Update-DR copies the shifted bit to `cpu_halt` (1 halts, 0 releases). Capture-DR loads the current `cpu_halt` value.
- R8: `cpu_halt` changes only on the edge leaving Update-DR with the halt opcode selected, or on an edge taken in the reset state.
- R9: All-ones and every undecoded opcode select a one-bit bypass stage. It captures 0 and passes `tdi` to `tdo` with one cycle of delay in Shift-DR.
- R10: With `HAS_NVM` = 0, loading 0x0F never sets busy and never pulses `erase_start`. The captured busy bit stays 0.
- R11: `tdo` is 0 in every state other than Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial scan data in |
| prot_i | input | 1 | Memory protection status, reported in the IR capture |
| erase_done_i | input | 1 | Erase completion from the memory controller |
| tdo | output | 1 | Serial scan data out |
| cpu_halt | output | 1 | Halt level to the processor core |
| erase_start | output | 1 | One-cycle erase request |

## Verification
The assertions assume that `erase_done_i` goes high only while an erase is running, and only for one cycle. They also assume that `tms` and `tdi` change away from the rising edge. The bench's memory stub raises the done pulse once, a randomly chosen number of cycles (at least 25) after each `erase_start`. All scan inputs change on the falling edge. Polling scans load the bypass opcode, so a new erase never starts after busy clears.

// File: rtl/tapx_pkg.sv
package tapx_pkg;

    typedef enum logic [3:0] {
        ST_RESET    = 4'd0,
        ST_IDLE     = 4'd1,
        ST_SEL_DR   = 4'd2,
        ST_CAP_DR   = 4'd3,
        ST_SH_DR    = 4'd4,
        ST_EX1_DR   = 4'd5,
        ST_PAUSE_DR = 4'd6,
        ST_EX2_DR   = 4'd7,
        ST_UPD_DR   = 4'd8,
        ST_SEL_IR   = 4'd9,
        ST_CAP_IR   = 4'd10,
        ST_SH_IR    = 4'd11,
        ST_EX1_IR   = 4'd12,
        ST_PAUSE_IR = 4'd13,
        ST_EX2_IR   = 4'd14,
        ST_UPD_IR   = 4'd15
    } tap_state_e;

endpackage

// File: rtl/tapx_fsm.sv
module tapx_fsm
    import tapx_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_q
);

    tap_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_d = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   state_d = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   state_d = tms ? ST_EX1_DR   : ST_SH_DR;
            ST_SH_DR:    state_d = tms ? ST_EX1_DR   : ST_SH_DR;
            ST_EX1_DR:   state_d = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: state_d = tms ? ST_EX2_DR   : ST_PAUSE_DR;
            ST_EX2_DR:   state_d = tms ? ST_UPD_DR   : ST_SH_DR;
            ST_UPD_DR:   state_d = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   state_d = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   state_d = tms ? ST_EX1_IR   : ST_SH_IR;
            ST_SH_IR:    state_d = tms ? ST_EX1_IR   : ST_SH_IR;
            ST_EX1_IR:   state_d = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: state_d = tms ? ST_EX2_IR   : ST_PAUSE_IR;
            ST_EX2_IR:   state_d = tms ? ST_UPD_IR   : ST_SH_IR;
            ST_UPD_IR:   state_d = tms ? ST_SEL_DR   : ST_IDLE;
            default:     state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

endmodule

// File: rtl/tapx_ir.sv
module tapx_ir
    import tapx_pkg::*;
#(
    parameter int              IR_W     = 5,
    parameter logic [IR_W-1:0] ERASE_OP = 5'h0F,
    parameter bit              HAS_NVM  = 1'b1
) (
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state_q,
    input  logic            tdi,
    input  logic            prot_i,
    input  logic            erase_done_i,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_tdo,
    output logic            busy,
    output logic            erase_start
);

    localparam logic [IR_W-1:0] BYPASS_OP = '1;
    localparam int              BUSY_POS  = 2;
    localparam int              PROT_POS  = IR_W - 1;

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] ir;
        logic            busy;
        logic            start;
    } ir_regs_t;

    ir_regs_t        r_d, r_q;
    logic [IR_W-1:0] cap_val;
    logic            load_erase;

    always_comb begin
        cap_val           = '0;
        cap_val[0]        = 1'b1;
        cap_val[BUSY_POS] = r_q.busy;
        cap_val[PROT_POS] = prot_i;
    end

    assign load_erase = HAS_NVM && (r_q.sh == ERASE_OP) && !r_q.busy;

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        if (r_q.busy && erase_done_i) begin
            r_d.busy = 1'b0;
        end
        unique case (state_q)
            ST_RESET:  r_d.ir = BYPASS_OP;
            ST_CAP_IR: r_d.sh = cap_val;
            ST_SH_IR:  r_d.sh = {tdi, r_q.sh[IR_W-1:1]};
            ST_UPD_IR: begin
                r_d.ir = r_q.sh;
                if (load_erase) begin
                    r_d.busy  = 1'b1;
                    r_d.start = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q.sh    <= '0;
            r_q.ir    <= BYPASS_OP;
            r_q.busy  <= 1'b0;
            r_q.start <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ir_q        = r_q.ir;
    assign ir_tdo      = r_q.sh[0];
    assign busy        = r_q.busy;
    assign erase_start = r_q.start;

endmodule

// File: rtl/tapx_dr.sv
module tapx_dr
    import tapx_pkg::*;
#(
    parameter int              IR_W     = 5,
    parameter logic [IR_W-1:0] HALT_OP  = 5'h11,
    parameter logic [IR_W-1:0] ERASE_OP = 5'h0F
) (
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state_q,
    input  logic [IR_W-1:0] ir_q,
    input  logic            tdi,
    output logic            dr_tdo,
    output logic            cpu_halt
);

    typedef struct packed {
        logic sh;
        logic halt;
    } dr_regs_t;

    dr_regs_t r_d, r_q;
    logic     sel_halt;
    logic     sel_erase;

    assign sel_halt  = (ir_q == HALT_OP);
    assign sel_erase = (ir_q == ERASE_OP);

    always_comb begin
        r_d = r_q;
        unique case (state_q)
            ST_RESET:  r_d.halt = 1'b0;
            ST_CAP_DR: r_d.sh   = sel_halt ? r_q.halt : 1'b0;
            ST_SH_DR:  r_d.sh   = sel_erase ? 1'b0 : tdi;
            ST_UPD_DR: if (sel_halt) r_d.halt = r_q.sh;
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q.sh   <= 1'b0;
            r_q.halt <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dr_tdo   = r_q.sh;
    assign cpu_halt = r_q.halt;

endmodule

// File: rtl/jtag_halt_erase.sv
module jtag_halt_erase
    import tapx_pkg::*;
#(
    parameter int              IR_W     = 5,
    parameter logic [IR_W-1:0] ERASE_OP = 5'h0F,
    parameter logic [IR_W-1:0] HALT_OP  = 5'h11,
    parameter bit              HAS_NVM  = 1'b1
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    input  logic prot_i,
    input  logic erase_done_i,
    output logic tdo,
    output logic cpu_halt,
    output logic erase_start
);

    tap_state_e      state_q;
    logic [IR_W-1:0] ir_q;
    logic            ir_tdo;
    logic            dr_tdo;
    logic            busy;

    tapx_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_q (state_q)
    );

    tapx_ir #(
        .IR_W     (IR_W),
        .ERASE_OP (ERASE_OP),
        .HAS_NVM  (HAS_NVM)
    ) u_ir (
        .tck          (tck),
        .trst_n       (trst_n),
        .state_q      (state_q),
        .tdi          (tdi),
        .prot_i       (prot_i),
        .erase_done_i (erase_done_i),
        .ir_q         (ir_q),
        .ir_tdo       (ir_tdo),
        .busy         (busy),
        .erase_start  (erase_start)
    );

    tapx_dr #(
        .IR_W     (IR_W),
        .HALT_OP  (HALT_OP),
        .ERASE_OP (ERASE_OP)
    ) u_dr (
        .tck      (tck),
        .trst_n   (trst_n),
        .state_q  (state_q),
        .ir_q     (ir_q),
        .tdi      (tdi),
        .dr_tdo   (dr_tdo),
        .cpu_halt (cpu_halt)
    );

    always_comb begin
        unique case (state_q)
            ST_SH_IR: tdo = ir_tdo;
            ST_SH_DR: tdo = dr_tdo;
            default:  tdo = 1'b0;
        endcase
    end

endmodule

// File: rtl/jtag_halt_erase_chk.sv
module jtag_halt_erase_chk
    import tapx_pkg::*;
#(
    parameter int              IR_W    = 5,
    parameter logic [IR_W-1:0] HALT_OP = 5'h11
) (
    input logic            tck,
    input logic            trst_n,
    input tap_state_e      state_q,
    input logic [IR_W-1:0] ir_q,
    input logic            busy,
    input logic            erase_start,
    input logic            erase_done_i,
    input logic            cpu_halt
);

    // R1
    reset_state_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == ST_RESET) |=> (ir_q == '1 && !cpu_halt));

    // R3
    start_sets_busy_chk: assert property (@(posedge tck) disable iff (!trst_n)
        erase_start |-> busy);

    // R3
    start_single_chk: assert property (@(posedge tck) disable iff (!trst_n)
        erase_start |=> !erase_start);

    // R3
    busy_rise_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(busy) |-> ($past(state_q) == ST_UPD_IR));

    // R5
    done_clears_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (busy && erase_done_i) |=> !busy);

    // R8
    halt_stable_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(cpu_halt) |->
            (($past(state_q) == ST_UPD_DR && $past(ir_q) == HALT_OP)
             || $past(state_q) == ST_RESET));

endmodule

bind jtag_halt_erase jtag_halt_erase_chk #(
    .IR_W    (IR_W),
    .HALT_OP (HALT_OP)
) u_chk (
    .tck          (tck),
    .trst_n       (trst_n),
    .state_q      (state_q),
    .ir_q         (ir_q),
    .busy         (busy),
    .erase_start  (erase_start),
    .erase_done_i (erase_done_i),
    .cpu_halt     (cpu_halt)
);

// File: tb/jtag_halt_erase_test.sv
`timescale 1ns/1ps
module jtag_halt_erase_test;

    localparam logic [4:0] OP_ERASE  = 5'h0F;
    localparam logic [4:0] OP_HALT   = 5'h11;
    localparam logic [4:0] OP_BYPASS = 5'h1F;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b0;
    logic tdi = 1'b0;
    logic prot = 1'b0;
    logic erase_done = 1'b0;
    logic tdo, cpu_halt, erase_start;
    logic tdo_b, halt_b, es_b;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    int pulses_b = 0;
    int stub_cnt = 0;
    bit finished = 0;

    always #2.5 tck = ~tck;

    jtag_halt_erase uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .prot_i(prot),
        .erase_done_i(erase_done), .tdo(tdo), .cpu_halt(cpu_halt),
        .erase_start(erase_start)
    );

    jtag_halt_erase #(.HAS_NVM(1'b0)) uut_bare (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .prot_i(prot),
        .erase_done_i(1'b0), .tdo(tdo_b), .cpu_halt(halt_b),
        .erase_start(es_b)
    );

    // memory controller stub: one done pulse a random delay after each start
    always @(negedge tck) begin
        erase_done <= 1'b0;
        if (erase_start) begin
            pulses   <= pulses + 1;
            stub_cnt <= 25 + int'($urandom % 30);
        end else if (stub_cnt != 0) begin
            stub_cnt <= stub_cnt - 1;
            if (stub_cnt == 1) erase_done <= 1'b1;
        end
        if (es_b) pulses_b <= pulses_b + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] cap_exp(input logic p, input logic b);
        return {p, 1'b0, b, 1'b0, 1'b1};
    endfunction

    task automatic step(input logic m, input logic d, output logic o, output logic ob);
        @(negedge tck);
        o   = tdo;
        ob  = tdo_b;
        tms = m;
        tdi = d;
    endtask

    task automatic scan_ir(input logic [4:0] v, output logic [4:0] cap, output logic [4:0] capb);
        logic o, ob;
        step(1, 0, o, ob); step(1, 0, o, ob); step(0, 0, o, ob); step(0, 0, o, ob);
        for (int i = 0; i < 5; i++) begin
            step(i == 4, v[i], o, ob);
            cap[i]  = o;
            capb[i] = ob;
        end
        step(1, 0, o, ob);
        step(0, 0, o, ob);
    endtask

    task automatic scan_dr2(input logic a, input logic b, output logic o0, output logic o1);
        logic o, ob;
        step(1, 0, o, ob); step(0, 0, o, ob); step(0, 0, o, ob);
        step(0, a, o0, ob);
        step(1, b, o1, ob);
        step(1, 0, o, ob);
        step(0, 0, o, ob);
    endtask

    task automatic scan_dr1(input logic v, output logic o0);
        logic o, ob;
        step(1, 0, o, ob); step(0, 0, o, ob); step(0, 0, o, ob);
        step(1, v, o0, ob);
        step(1, 0, o, ob);
        step(0, 0, o, ob);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [4:0] cap, capb;
        logic o0, o1, o, ob, hv;
        int polls;
        void'($urandom(32'd1234));

        // R1 reset state
        repeat (3) @(negedge tck);
        chk("R1 halt in reset", cpu_halt, 0);
        chk("R11 tdo in reset", tdo, 0);
        trst_n = 1'b1;
        step(0, 0, o, ob);
        @(negedge tck);
        chk("R11 tdo idle", tdo, 0);

        // R9 bypass after reset: one-cycle delay
        scan_dr2(1, 0, o0, o1);
        chk("R9 bypass capture", o0, 0);
        chk("R9 bypass delay", o1, 1);

        // R2 capture pattern with both protect values
        for (int k = 0; k < 2; k++) begin
            prot = k[0];
            scan_ir(OP_BYPASS, cap, capb);
            chk("R2 ir capture", cap, cap_exp(k[0], 0));
        end
        prot = 1'b0;

        // R7 halt set and read back
        scan_ir(OP_HALT, cap, capb);
        scan_dr1(1, o0);
        chk("R7 halt capture before", o0, 0);
        @(negedge tck);
        chk("R7 halt set", cpu_halt, 1);
        scan_dr1(1, o0);
        chk("R7 halt capture when halted", o0, 1);

        // R8 halt stable across bypass scans and IR scans
        scan_ir(5'h03, cap, capb);
        scan_dr2(0, 0, o0, o1);
        @(negedge tck);
        chk("R8 halt stable", cpu_halt, 1);

        // R1 TMS-high reset clears halt and selects bypass
        for (int i = 0; i < 5; i++) step(1, 0, o, ob);
        step(0, 0, o, ob);
        @(negedge tck);
        chk("R1 tms reset halt", cpu_halt, 0);
        scan_dr2(1, 1, o0, o1);
        chk("R1 bypass after tms reset", o1, 1);

        // R3 erase start on IR update alone
        scan_ir(OP_ERASE, cap, capb);
        @(negedge tck);
        chk("R3 start pulse", erase_start, 1);
        @(negedge tck);
        chk("R3 pulse width", erase_start, 0);
        // R4 reload while busy
        scan_ir(OP_ERASE, cap, capb);
        chk("R4 busy in capture", cap, cap_exp(0, 1));
        chk("R10 bare capture", capb, cap_exp(0, 0));
        @(negedge tck);
        chk("R4 no restart", erase_start, 0);
        // R6 erase data stage ignores tdi
        scan_dr2(1, 1, o0, o1);
        chk("R6 erase capture", o0, 0);
        chk("R6 erase ignores tdi", o1, 0);
        // R5 poll until busy clears
        polls = 0;
        do begin
            scan_ir(OP_BYPASS, cap, capb);
            polls++;
        end while (cap[2] && polls < 50);
        chk("R5 busy cleared", cap, cap_exp(0, 0));
        chk("R4 one pulse", pulses, 1);
        chk("R10 bare no pulse", pulses_b, 0);

        // random halt writes and bypass data
        for (int n = 0; n < 20; n++) begin
            hv = $urandom % 2;
            scan_ir(OP_HALT, cap, capb);
            scan_dr1(hv, o0);
            @(negedge tck);
            chk("R7 random halt", cpu_halt, hv);
            chk("R7 bare halt", halt_b, hv);
            scan_ir(OP_BYPASS, cap, capb);
            o0 = $urandom % 2;
            scan_dr2(o0, 0, o, o1);
            chk("R9 random bypass", o1, o0);
            @(negedge tck);
            chk("R8 random halt stable", cpu_halt, hv);
        end

        // second erase with protect set, random delay
        prot = 1'b1;
        scan_ir(OP_ERASE, cap, capb);
        chk("R2 capture protect", cap, cap_exp(1, 0));
        scan_ir(OP_BYPASS, cap, capb);
        chk("R3 busy after start", cap, cap_exp(1, 1));
        chk("R10 bare never busy", capb, cap_exp(1, 0));
        polls = 0;
        do begin
            scan_ir(OP_BYPASS, cap, capb);
            polls++;
        end while (cap[2] && polls < 50);
        chk("R5 second clear", cap[2], 0);
        chk("R3 two pulses", pulses, 2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule